// File: doc/BRIEF.md
# Price Level Aggregation Table

This block holds one aggregated record per price level of a single instrument's book. The buy side and the sell side share one table. A caller presents a command that carries a side, a price, a share quantity and a flag that says whether shares are added or taken away. The block turns the low bits of the price into a table slot. It reads the slot's current record, works out the new record and writes it back.

The update path is a short pipeline. The first stage latches the command and reads the old record. The second stage computes the new record and the level-count change. A write register then commits the record to storage. A command that follows at once and targets the same slot would read the stale record. Forwarding from the write register gives it the fresh one instead. A second, independent read port serves a scanning client. It has a fixed two-cycle registered latency. The block also keeps live counts of occupied bid levels and occupied ask levels.

Top module: `level_agg_table`

## Requirements
- R1: The price index is the low log2(LEVELS_PER_SIDE) bits of the price (7 bits by default). Side 0 is buy and side 1 is sell. A buy maps to slot index+1 (1..128) and a sell maps to slot index+129 (129..255).
- R2: A sell command whose index is the top value (127) would land outside the table. It is not accepted: busy stays low, no slot changes, no count changes, and slot 0 is never written.
- R3: An add to an inactive slot makes it active. It stores the command's price and side, sets shares to the quantity and sets the order count to 1.
- R4: An add to an active slot adds the quantity to the shares and adds one to the order count. The stored price and side are kept.
- R5: A remove from an active slot subtracts the quantity from the shares, stopping at zero, and takes one from the order count. The slot becomes inactive as soon as either the shares or the order count is zero.
- R6: A remove that targets an inactive slot changes nothing.
- R7: bid_levels and ask_levels count the active slots of each side. Each count rises when a slot of its side turns active and falls when one turns inactive.
- R8: After a command is accepted, busy is high for exactly the next cycle. A command offered while busy is high is dropped.
- R9: A command accepted two cycles after a command to the same slot builds on that command's result.
- R10: rd_req sampled at an edge produces rd_valid and the slot's fields two edges later. The read shows every command accepted at least three cycles before the request.
- R11: After reset, busy is low, both counts are zero, rd_valid is low and every slot is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_side | input | 1 | 0 buy, 1 sell |
| cmd_price | input | 32 | Level price; low bits select the slot |
| cmd_shares | input | 32 | Share quantity to add or remove |
| cmd_remove | input | 1 | 1 remove, 0 add |
| busy | output | 1 | High in the cycle after an accepted command |
| rd_req | input | 1 | Scanner read request |
| rd_addr | input | 8 | Scanner slot address |
| rd_valid | output | 1 | Scanner data valid |
| rd_price | output | 32 | Slot price |
| rd_shares | output | 32 | Slot total shares |
| rd_orders | output | 16 | Slot order count |
| rd_side | output | 1 | Slot side |
| rd_live | output | 1 | Slot active flag |
| bid_levels | output | 8 | Active bid slot count |
| ask_levels | output | 8 | Active ask slot count |

## Verification
The bench sends two commands to one slot as close together as busy allows, once as add then add and once as add then remove. A design without forwarding would rebuild the slot from the stale inactive record, lose the first quantity and double-count the level. It aims at both ends of each half of the table and at the sell index that overflows. Getting the offset wrong would either corrupt slot 0 or alias the two sides. It also drives removes that saturate the shares and removes that empty the order count while shares remain. A flawed clearing rule would leave a dead level counted as active. Finally, it offers a command during the busy cycle; a design that failed to drop it would activate an extra slot and bump bid_levels.

// File: rtl/lvl_agg_pkg.sv
package lvl_agg_pkg;

  localparam int PRICE_W = 32;
  localparam int SHARE_W = 32;
  localparam int ORD_W   = 16;

  typedef struct packed {
    logic [PRICE_W-1:0] price;
    logic [SHARE_W-1:0] shares;
    logic [ORD_W-1:0]   orders;
    logic               side;
    logic               live;
  } level_t;

  localparam int LEVEL_W = $bits(level_t);

  // New record for one command applied to an old record.
  function automatic level_t level_apply(input level_t old, input logic rm,
                                         input logic side,
                                         input logic [PRICE_W-1:0] price,
                                         input logic [SHARE_W-1:0] qty);
    level_t nxt;
    nxt = old;
    if (!rm) begin
      if (!old.live) begin
        nxt.price  = price;
        nxt.shares = qty;
        nxt.orders = ORD_W'(1);
        nxt.side   = side;
        nxt.live   = 1'b1;
      end else begin
        nxt.shares = old.shares + qty;
        nxt.orders = old.orders + ORD_W'(1);
      end
    end else if (old.live) begin
      nxt.shares = (qty >= old.shares) ? '0 : old.shares - qty;
      nxt.orders = (old.orders == '0) ? '0 : old.orders - ORD_W'(1);
      if (nxt.shares == '0 || nxt.orders == '0) nxt.live = 1'b0;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/lvl_addr_map.sv
module lvl_addr_map #(
  parameter int LEVELS = 128,
  parameter int AW     = 8
) (
  input  logic                        side,
  input  logic [$clog2(LEVELS)-1:0]   idx,
  output logic [AW-1:0]               addr,
  output logic                        in_range
);
  localparam int DEPTH = 2 * LEVELS;

  logic [AW:0] sum;

  always_comb begin
    sum      = (AW+1)'(idx) + (side ? (AW+1)'(LEVELS + 1) : (AW+1)'(1));
    in_range = (sum < (AW+1)'(DEPTH));
    addr     = sum[AW-1:0];
  end
endmodule

// File: rtl/lvl_store.sv
module lvl_store
  import lvl_agg_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  output level_t        a_q,
  input  logic          w_en,
  input  logic [AW-1:0] w_addr,
  input  level_t        w_data,
  input  logic          b_re,
  input  logic [AW-1:0] b_addr,
  output logic          b_valid,
  output level_t        b_q
);
  level_t     mem [DEPTH];
  logic [DEPTH-1:0] live_bits;

  level_t a_raw, b1_raw, b_raw;
  logic   a_live, b1_live, b_live, b1_v;

  // Payload array: read-first, no reset.
  always_ff @(posedge clk) begin
    if (a_re) a_raw <= mem[a_addr];
    if (b_re) b1_raw <= mem[b_addr];
    b_raw <= b1_raw;
    if (w_en) mem[w_addr] <= w_data;
  end

  // Active flags kept in resettable flops beside the payload.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_bits <= '0;
      a_live    <= 1'b0;
      b1_live   <= 1'b0;
      b_live    <= 1'b0;
      b1_v      <= 1'b0;
      b_valid   <= 1'b0;
    end else begin
      if (a_re) a_live <= live_bits[a_addr];
      if (b_re) b1_live <= live_bits[b_addr];
      if (w_en) live_bits[w_addr] <= w_data.live;
      b1_v    <= b_re;
      b_valid <= b1_v;
      b_live  <= b1_live;
    end
  end

  always_comb begin
    a_q      = a_raw;
    a_q.live = a_live;
    b_q      = b_raw;
    b_q.live = b_live;
  end
endmodule

// File: rtl/lvl_count.sv
module lvl_count #(
  parameter int LEVELS = 128,
  parameter int CW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up,
  input  logic          down,
  input  logic          side,
  output logic [CW-1:0] bid_cnt,
  output logic [CW-1:0] ask_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bid_cnt <= '0;
      ask_cnt <= '0;
    end else if (up) begin
      if (side) ask_cnt <= ask_cnt + CW'(1);
      else      bid_cnt <= bid_cnt + CW'(1);
    end else if (down) begin
      if (side) ask_cnt <= ask_cnt - CW'(1);
      else      bid_cnt <= bid_cnt - CW'(1);
    end
  end
endmodule

// File: rtl/level_agg_table.sv
module level_agg_table
  import lvl_agg_pkg::*;
#(
  parameter int LEVELS_PER_SIDE = 128
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cmd_valid,
  input  logic                                   cmd_side,
  input  logic [PRICE_W-1:0]                     cmd_price,
  input  logic [SHARE_W-1:0]                     cmd_shares,
  input  logic                                   cmd_remove,
  output logic                                   busy,
  input  logic                                   rd_req,
  input  logic [$clog2(2*LEVELS_PER_SIDE)-1:0]   rd_addr,
  output logic                                   rd_valid,
  output logic [PRICE_W-1:0]                     rd_price,
  output logic [SHARE_W-1:0]                     rd_shares,
  output logic [ORD_W-1:0]                       rd_orders,
  output logic                                   rd_side,
  output logic                                   rd_live,
  output logic [$clog2(LEVELS_PER_SIDE+1)-1:0]   bid_levels,
  output logic [$clog2(LEVELS_PER_SIDE+1)-1:0]   ask_levels
);
  localparam int DEPTH = 2 * LEVELS_PER_SIDE;
  localparam int AW    = $clog2(DEPTH);
  localparam int IW    = $clog2(LEVELS_PER_SIDE);
  localparam int CW    = $clog2(LEVELS_PER_SIDE + 1);

  // Slot mapping of the offered command
  logic [AW-1:0] map_addr;
  logic          map_ok;
  logic          cmd_accept;

  lvl_addr_map #(.LEVELS(LEVELS_PER_SIDE), .AW(AW)) i_map (
    .side     (cmd_side),
    .idx      (cmd_price[IW-1:0]),
    .addr     (map_addr),
    .in_range (map_ok)
  );

  // Stage 1: latched command, read in flight
  logic               s1_valid, s1_side, s1_rm;
  logic [PRICE_W-1:0] s1_price;
  logic [SHARE_W-1:0] s1_qty;
  logic [AW-1:0]      s1_addr;
  logic               fwd_hit;
  level_t             fwd_data;

  // Write register: computed record waiting to commit
  logic               wr_fire;
  logic [AW-1:0]      wr_addr;
  level_t             wr_data;

  level_t mem_q, old_eff, new_ent;
  logic   lvl_up, lvl_down;
  level_t scan_q;

  assign busy       = s1_valid;
  assign cmd_accept = cmd_valid && !busy && map_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_side  <= 1'b0;
      s1_rm    <= 1'b0;
      s1_price <= '0;
      s1_qty   <= '0;
      s1_addr  <= '0;
      fwd_hit  <= 1'b0;
      fwd_data <= '0;
    end else begin
      s1_valid <= cmd_accept;
      if (cmd_accept) begin
        s1_side  <= cmd_side;
        s1_rm    <= cmd_remove;
        s1_price <= cmd_price;
        s1_qty   <= cmd_shares;
        s1_addr  <= map_addr;
        // Same-edge commit to the same slot: storage returns the old record.
        fwd_hit  <= wr_fire && (wr_addr == map_addr);
        fwd_data <= wr_data;
      end
    end
  end

  // Stage 2: compute
  always_comb begin
    old_eff  = fwd_hit ? fwd_data : mem_q;
    new_ent  = level_apply(old_eff, s1_rm, s1_side, s1_price, s1_qty);
    lvl_up   = s1_valid && !old_eff.live && new_ent.live;
    lvl_down = s1_valid && old_eff.live && !new_ent.live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_fire <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_fire <= s1_valid;
      if (s1_valid) begin
        wr_addr <= s1_addr;
        wr_data <= new_ent;
      end
    end
  end

  lvl_store #(.DEPTH(DEPTH), .AW(AW)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_re    (cmd_accept),
    .a_addr  (map_addr),
    .a_q     (mem_q),
    .w_en    (wr_fire),
    .w_addr  (wr_addr),
    .w_data  (wr_data),
    .b_re    (rd_req),
    .b_addr  (rd_addr),
    .b_valid (rd_valid),
    .b_q     (scan_q)
  );

  lvl_count #(.LEVELS(LEVELS_PER_SIDE), .CW(CW)) i_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .up      (lvl_up),
    .down    (lvl_down),
    .side    (s1_side),
    .bid_cnt (bid_levels),
    .ask_cnt (ask_levels)
  );

  assign rd_price  = scan_q.price;
  assign rd_shares = scan_q.shares;
  assign rd_orders = scan_q.orders;
  assign rd_side   = scan_q.side;
  assign rd_live   = scan_q.live;
endmodule

// File: rtl/lvl_agg_chk.sv
module lvl_agg_chk #(
  parameter int LEVELS = 128,
  parameter int AW     = 8,
  parameter int CW     = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          cmd_accept,
  input logic          wr_fire,
  input logic [AW-1:0] wr_addr,
  input logic          lvl_up,
  input logic          lvl_down,
  input logic          rd_req,
  input logic          rd_valid,
  input logic [CW-1:0] bid_levels,
  input logic [CW-1:0] ask_levels
);
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> busy); // R8
  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy); // R8
  AST_SLOT_ZERO_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (wr_addr != '0)); // R2
  AST_SCAN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> ##1 rd_valid); // R10
  AST_SCAN_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> ##1 !rd_valid); // R10
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (bid_levels <= CW'(LEVELS)) && (ask_levels <= CW'(LEVELS))); // R7
  AST_BID_COUNT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bid_levels) |-> $past(lvl_up || lvl_down)); // R7
  AST_ASK_COUNT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ask_levels) |-> $past(lvl_up || lvl_down)); // R7
endmodule

bind level_agg_table lvl_agg_chk #(
  .LEVELS (LEVELS_PER_SIDE),
  .AW     ($clog2(2*LEVELS_PER_SIDE)),
  .CW     ($clog2(LEVELS_PER_SIDE+1))
) i_lvl_agg_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .cmd_accept (cmd_accept),
  .wr_fire    (wr_fire),
  .wr_addr    (wr_addr),
  .lvl_up     (lvl_up),
  .lvl_down   (lvl_down),
  .rd_req     (rd_req),
  .rd_valid   (rd_valid),
  .bid_levels (bid_levels),
  .ask_levels (ask_levels)
);

// File: tb/test_level_agg_table.sv
module test_level_agg_table;
  localparam int L = 128;
  localparam int D = 2 * L;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_side, cmd_remove;
  logic [31:0] cmd_price, cmd_shares;
  logic        busy;
  logic        rd_req;
  logic [7:0]  rd_addr;
  logic        rd_valid, rd_side, rd_live;
  logic [31:0] rd_price, rd_shares;
  logic [15:0] rd_orders;
  logic [7:0]  bid_levels, ask_levels;

  always #5 clk = ~clk;

  level_agg_table #(.LEVELS_PER_SIDE(L)) i_level_agg_table (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_side(cmd_side), .cmd_price(cmd_price),
    .cmd_shares(cmd_shares), .cmd_remove(cmd_remove), .busy(busy),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_price(rd_price), .rd_shares(rd_shares), .rd_orders(rd_orders),
    .rd_side(rd_side), .rd_live(rd_live),
    .bid_levels(bid_levels), .ask_levels(ask_levels)
  );

  // Reference state, written from the requirements
  logic [31:0] m_price  [D];
  logic [31:0] m_shares [D];
  logic [15:0] m_orders [D];
  logic        m_side   [D];
  logic        m_live   [D];
  int          m_bid, m_ask;

  typedef struct {
    string       req;
    logic        live;
    logic [31:0] price;
    logic [31:0] shares;
    logic [15:0] orders;
    logic        side;
  } exp_t;
  exp_t sb[$];

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R1: slot of a side/price pair; D means outside the table
  function automatic int slot_of(logic side, logic [31:0] price);
    int idx;
    idx = int'(price[6:0]);
    if (side) return idx + L + 1;
    return idx + 1;
  endfunction

  task automatic model_cmd(logic side, logic [31:0] price, logic [31:0] qty, logic rm);
    int a;
    a = slot_of(side, price);
    if (a >= D) return;                       // R2
    if (rm) begin
      if (!m_live[a]) return;                 // R6
      if (m_shares[a] > qty) m_shares[a] = m_shares[a] - qty;
      else m_shares[a] = 0;                   // R5
      m_orders[a] = m_orders[a] - 16'd1;
      if (m_shares[a] == 0 || m_orders[a] == 0) begin
        m_live[a] = 1'b0;
        if (side) m_ask--; else m_bid--;      // R7
      end
    end else if (m_live[a]) begin             // R4
      m_shares[a] = m_shares[a] + qty;
      m_orders[a] = m_orders[a] + 16'd1;
    end else begin                            // R3
      m_live[a]   = 1'b1;
      m_price[a]  = price;
      m_side[a]   = side;
      m_shares[a] = qty;
      m_orders[a] = 16'd1;
      if (side) m_ask++; else m_bid++;
    end
  endtask

  // Driver: enters and leaves on a falling edge
  task automatic send(logic side, logic [31:0] price, logic [31:0] qty, logic rm);
    while (busy) @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_side   = side;
    cmd_price  = price;
    cmd_shares = qty;
    cmd_remove = rm;
    @(negedge clk);
    cmd_valid = 1'b0;
    model_cmd(side, price, qty, rm);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic scan(string req, int a);
    exp_t e;
    e.req    = req;
    e.live   = m_live[a];
    e.price  = m_price[a];
    e.shares = m_shares[a];
    e.orders = m_orders[a];
    e.side   = m_side[a];
    sb.push_back(e);
    rd_req  = 1'b1;
    rd_addr = 8'(a);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic counts(string req);
    check(req, "bid_levels", bid_levels, m_bid);
    check(req, "ask_levels", ask_levels, m_ask);
  endtask

  // Monitor: pops the scoreboard as scanner data appears
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && rd_valid) begin
      if (sb.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R10 rd_valid actual=1 expected=0");
      end else begin
        e = sb.pop_front();
        check(e.req, "rd_live", rd_live, e.live);
        if (e.live) begin
          check(e.req, "rd_price", rd_price, e.price);
          check(e.req, "rd_shares", rd_shares, e.shares);
          check(e.req, "rd_orders", rd_orders, e.orders);
          check(e.req, "rd_side", rd_side, e.side);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) begin
      m_live[i] = 1'b0; m_price[i] = '0; m_shares[i] = '0;
      m_orders[i] = '0; m_side[i] = 1'b0;
    end
    m_bid = 0; m_ask = 0;
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_side = 1'b0; cmd_remove = 1'b0;
    cmd_price = '0; cmd_shares = '0;
    rd_req = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    check("R11", "busy", busy, 0);
    check("R11", "rd_valid", rd_valid, 0);
    counts("R11");
    rst_n = 1'b1;
    @(negedge clk);
    scan("R11", 97);
    scan("R11", 200);

    // R9: two adds to slot 97 as close as busy allows
    send(1'b0, 32'h0016E360, 32'd300, 1'b0);
    send(1'b0, 32'h0016E360, 32'd200, 1'b0);
    settle();
    scan("R9 R4", 97);                        // 500 shares, 2 orders
    counts("R9 R7");

    // R1 R3: sell with index 5 lands in slot 134
    send(1'b1, 32'h0016D985, 32'd50, 1'b0);
    settle();
    scan("R1 R3", 134);
    counts("R7");

    // R5: remove beyond the shares saturates to zero and clears
    send(1'b1, 32'h0016D985, 32'd1000, 1'b0 | 1'b1);
    settle();
    scan("R5", 134);
    counts("R5 R7");

    // R6: remove from inactive slot
    send(1'b1, 32'h0016D985, 32'd10, 1'b1);
    settle();
    scan("R6", 134);
    counts("R6");

    // R5: partial remove keeps the slot active
    send(1'b0, 32'h0016E360, 32'd200, 1'b1);
    settle();
    scan("R5", 97);

    // R2: sell at the top index is refused
    cmd_valid = 1'b1; cmd_side = 1'b1; cmd_price = 32'h000000FF;
    cmd_shares = 32'd10; cmd_remove = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R2", "busy", busy, 0);
    settle();
    scan("R2", 0);
    scan("R2", 255);
    counts("R2");

    // R1: top buy index and bottom sell index
    send(1'b0, 32'h0000017F, 32'd5, 1'b0);
    send(1'b1, 32'h00001000, 32'd7, 1'b0);
    settle();
    scan("R1", 128);
    scan("R1", 129);
    counts("R1 R7");

    // R8: command offered during busy is dropped
    send(1'b0, 32'h00000202, 32'd40, 1'b0);
    check("R8", "busy", busy, 1);
    cmd_valid = 1'b1; cmd_side = 1'b0; cmd_price = 32'h0000000A;
    cmd_shares = 32'd99; cmd_remove = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    settle();
    scan("R8", 11);
    scan("R8", 3);
    counts("R8");

    // R5: order count reaching zero clears although shares remain
    send(1'b0, 32'h0016E360, 32'd1, 1'b1);
    // R5: shares reaching zero clear
    send(1'b0, 32'h0000017F, 32'd5, 1'b1);
    settle();
    scan("R5", 97);
    scan("R5", 128);
    counts("R5 R7");

    // R9: add then remove on slot 3 back to back
    send(1'b0, 32'h00000202, 32'd10, 1'b0);
    send(1'b0, 32'h00000202, 32'd50, 1'b1);
    settle();
    scan("R9", 3);
    counts("R9 R7");

    repeat (4) @(negedge clk);
    check("R10", "pending reads", sb.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule